// File: doc/BRIEF.md
# Period and Rate Frequency Meter

This block turns a slowly varying input signal into a frequency reading. In the two period modes it counts ticks of a fixed reference while a gate, formed from the Z input, is in its ON phase. At the end of that phase it stores the count, from which the host computes frequency as reference rate divided by count. In rate mode it counts rising edges on the A input over a host-chosen number of millisecond ticks, which gives pulses per interval directly.

A gate that stays ON so long that the 24-bit count saturates is reported as zero frequency, and so is a rate interval with no pulses. Each refresh of the stored result advances a two-bit tag. A host that polls at least as fast as results arrive can compare tags to tell a fresh sample from one it has already read. A status field mirrors the physical A, B and Z levels after synchronization.

Top module: `freq_meter`

## Requirements
- R1: `raw_status` shows the physical levels {Z, B, A} (bit 2 = Z, bit 0 = A) two clocks after they change at the pins, and `z_invert` does not affect it.
- R2: In modes 5 and 6 the gate is Z XOR `z_invert`. One reference tick occurs every REF_DIV clocks, and the live count advances on each tick seen while a started measurement has the gate ON. When the gate falls, the count moves to `stored_count` and the live count clears.
- R3: The live count saturates at 2^CNT_W-1 rather than wrapping. `zero_freq` rises as soon as the count saturates, and the stored result of that measurement equals all ones with `zero_freq` = 1.
- R4: In mode 7 the block counts rising edges of A over `timebase` millisecond ticks, one tick being TICK_DIV clocks. At the end of each interval it stores the count, and `zero_freq` is 1 when the count is zero.
- R5: `update_tag` steps by one modulo 4 (00, 01, 10, 11, 00) in the same cycle that `stored_count` is refreshed. Both hold their values otherwise.
- R6: In mode 5 a gate rising edge starts a measurement only after a one-cycle `arm` pulse. Each arm allows exactly one measurement, and ON phases that arrive without an arm leave the outputs unchanged.
- R7: In mode 6 every ON phase of the gate is measured without arming, each giving its own result.
- R8: `zero_freq` clears on the next result that is neither saturated nor zero.
- R9: In modes other than 5, 6 and 7, `zero_freq` reads 0 and no result is stored. Any change of `mode` abandons the measurement in progress and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | 5 single period, 6 continuous period, 7 rate, other values idle |
| arm | input | 1 | One-cycle request for a single measurement in mode 5 |
| z_invert | input | 1 | Use the low phase of Z as the gate |
| timebase | input | TB_W | Rate interval length in millisecond ticks |
| in_a | input | 1 | Pulse input counted in rate mode |
| in_b | input | 1 | Input reported in status only |
| in_z | input | 1 | Gate input for the period modes |
| stored_count | output | CNT_W | Last stored result |
| update_tag | output | 2 | Counter that advances on each stored refresh |
| zero_freq | output | 1 | Zero-frequency flag |
| raw_status | output | 3 | Synchronized {Z, B, A} levels |

## Verification
A pin change appears in `raw_status` two clock edges later. A gate fall at the pins reaches `stored_count` and `update_tag` on the third edge after it. The saturation flag rises one edge after the count reaches its limit. With a reference tick on every clock, a Z ON phase of N clocks yields exactly N.

Results therefore arrive at times that depend on pin history, so the driver places each expected result in a queue when it issues the stimulus. A monitor compares against that queue only on the sample where the tag moves, and it flags any movement that nothing expected. Rate stimulus keeps its pulses well inside each interval, so the counts do not depend on exactly where the boundaries fall.

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CNT_W    = 24,
  parameter int REF_DIV  = 40,
  parameter int TICK_DIV = 200000,
  parameter int TB_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             arm,
  input  logic             z_invert,
  input  logic [TB_W-1:0]  timebase,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_z,
  output logic [CNT_W-1:0] stored_count,
  output logic [1:0]       update_tag,
  output logic             zero_freq,
  output logic [2:0]       raw_status
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int REF_W  = $clog2(REF_DIV + 1);
  localparam int TICK_W = $clog2(TICK_DIV + 1);
  localparam logic [2:0] M_SINGLE = 3'd5;
  localparam logic [2:0] M_CONT   = 3'd6;
  localparam logic [2:0] M_RATE   = 3'd7;

  logic [2:0]       sync1, sync2;
  logic             gate_d, a_d;
  logic [2:0]       mode_q;
  logic [REF_W-1:0] ref_cnt;
  logic [TICK_W-1:0] pre;
  logic [TB_W-1:0]  iv_cnt;
  logic [CNT_W-1:0] live;
  logic             measuring, armed, zf_q;

  wire gate      = sync2[2] ^ z_invert;
  wire g_rise    = gate & ~gate_d;
  wire g_fall    = ~gate & gate_d;
  wire a_rise    = sync2[0] & ~a_d;
  wire clr       = mode != mode_q;
  wire per_mode  = (mode == M_SINGLE) || (mode == M_CONT);
  wire rate_mode = mode == M_RATE;
  wire ref_tick  = ref_cnt == REF_W'(REF_DIV - 1);
  wire ms_tick   = rate_mode && (pre == TICK_W'(TICK_DIV - 1));
  wire start     = per_mode && g_rise && ((mode == M_CONT) || armed);
  wire cnt_en    = per_mode ? (ref_tick && gate && (measuring || start)) : (rate_mode && a_rise);
  wire [CNT_W-1:0] live_inc = (live == CNT_MAX) ? live : live + CNT_W'(cnt_en);
  wire iv_end    = ms_tick && ((TB_W+1)'(iv_cnt) + (TB_W+1)'(1) >= (TB_W+1)'(timebase));
  wire latch     = (per_mode && measuring && g_fall) || (rate_mode && iv_end);

  assign raw_status = sync2;
  assign zero_freq  = zf_q && (per_mode || rate_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; gate_d <= 1'b0; a_d <= 1'b0;
      ref_cnt <= '0;
      mode_q <= '0;
    end else begin
      sync1   <= {in_z, in_b, in_a};
      sync2   <= sync1;
      gate_d  <= gate;
      a_d     <= sync2[0];
      ref_cnt <= ref_tick ? '0 : ref_cnt + REF_W'(1);
      mode_q  <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0; measuring <= 1'b0; armed <= 1'b0; zf_q <= 1'b0;
      pre <= '0; iv_cnt <= '0;
      stored_count <= '0; update_tag <= '0;
    end else if (clr) begin
      live <= '0; measuring <= 1'b0; armed <= 1'b0; zf_q <= 1'b0;
      pre <= '0; iv_cnt <= '0;
    end else begin
      if (mode == M_SINGLE && arm) armed <= 1'b1;
      if (rate_mode) pre <= ms_tick ? '0 : pre + TICK_W'(1);
      if (ms_tick)   iv_cnt <= iv_end ? '0 : iv_cnt + TB_W'(1);
      if (latch) begin
        stored_count <= live_inc;
        update_tag   <= update_tag + 2'd1;
        live         <= '0;
        measuring    <= 1'b0;
        zf_q         <= (live_inc == CNT_MAX) || (live_inc == '0);
      end else begin
        live <= live_inc;
        if (live_inc == CNT_MAX) zf_q <= 1'b1;
        if (start) begin
          measuring <= 1'b1;
          armed     <= 1'b0;
        end
      end
    end
  end

  assert_tag_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(update_tag) |-> (update_tag == $past(update_tag) + 2'd1));

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(update_tag) |-> $stable(stored_count));

  assert_sat_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_mode && !clr && measuring && gate && live == CNT_MAX) |=> zf_q);

  assert_no_unarmed_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SINGLE && !clr && g_rise && !armed && !measuring) |=> !measuring);

  assert_empty_interval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_mode && !clr && iv_end && live_inc == '0) |=> zf_q);

endmodule

// File: tb/freq_meter_bench.sv
`timescale 1ns/1ps
module freq_meter_bench;
  localparam int CNT_W = 8;
  localparam int TB_W  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic arm = 1'b0, z_invert = 1'b0, in_a = 1'b0, in_b = 1'b0, in_z = 1'b0;
  logic [TB_W-1:0] timebase = 8'd10;
  logic [CNT_W-1:0] stored_count;
  logic [1:0] update_tag;
  logic zero_freq;
  logic [2:0] raw_status;

  int checks = 0, failures = 0;
  int exp_cnt_q[$];
  int exp_zf_q[$];
  string cur_req = "R2";
  logic [1:0] last_tag = 2'd0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  freq_meter #(.CNT_W(CNT_W), .REF_DIV(1), .TICK_DIV(4), .TB_W(TB_W)) u_freq_meter (
    .clk(clk), .rst_n(rst_n), .mode(mode), .arm(arm), .z_invert(z_invert),
    .timebase(timebase), .in_a(in_a), .in_b(in_b), .in_z(in_z),
    .stored_count(stored_count), .update_tag(update_tag),
    .zero_freq(zero_freq), .raw_status(raw_status));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_result(input int cnt, input int zf);
    exp_cnt_q.push_back(cnt);
    exp_zf_q.push_back(zf);
  endtask

  task automatic z_phase(input int n, input bit on_level);
    in_z = on_level;
    tick(n);
    in_z = ~on_level;
    tick(8);
  endtask

  task automatic rate_interval(input int n);
    expect_result(n, (n == 0) ? 1 : 0);
    tick(6);
    for (int i = 0; i < n; i++) begin
      in_a = 1'b1; tick(1);
      in_a = 1'b0; tick(1);
    end
    tick(34 - 2 * n);
  endtask

  always @(negedge clk) begin
    if (rst_n && update_tag != last_tag) begin
      chk(update_tag == last_tag + 2'd1, "R5", update_tag, last_tag + 2'd1);
      if (exp_cnt_q.size() == 0) begin
        chk(1'b0, cur_req, update_tag, last_tag);
      end else begin
        int ec, ez;
        ec = exp_cnt_q.pop_front();
        ez = exp_zf_q.pop_front();
        chk(stored_count == CNT_W'(ec), cur_req, stored_count, ec);
        chk(zero_freq == ez[0], {cur_req, " R8 flag"}, zero_freq, ez);
      end
      last_tag = update_tag;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(stored_count == 0, "R5 reset", stored_count, 0);
    chk(update_tag == 0, "R5 reset", update_tag, 0);
    chk(zero_freq == 0, "R9 reset", zero_freq, 0);

    // R1: raw levels, Z invert has no effect on status
    in_a = 1'b1; in_b = 1'b0; in_z = 1'b1; z_invert = 1'b1;
    tick(3);
    chk(raw_status == 3'b101, "R1", raw_status, 5);
    in_a = 1'b0; in_b = 1'b1;
    tick(3);
    chk(raw_status == 3'b110, "R1", raw_status, 6);
    in_b = 1'b0;

    // R2/R7 inverted gate in continuous mode: Z low phase is measured
    mode = 3'd6; cur_req = "R2";
    tick(5);
    expect_result(15, 0);
    z_phase(15, 1'b0);
    mode = 3'd0; in_z = 1'b0; tick(2); z_invert = 1'b0; tick(5);

    // R7: back-to-back ON phases each measured
    mode = 3'd6; cur_req = "R7";
    tick(5);
    expect_result(10, 0); z_phase(10, 1'b1);
    expect_result(25, 0); z_phase(25, 1'b1);

    // R3: saturation raises the flag mid-gate and stores all ones
    cur_req = "R3";
    expect_result(255, 1);
    in_z = 1'b1;
    tick(265);
    chk(zero_freq == 1'b1, "R3 mid-gate", zero_freq, 1);
    tick(35);
    in_z = 1'b0;
    tick(8);
    // R8: next good result clears the flag
    cur_req = "R8";
    expect_result(30, 0); z_phase(30, 1'b1);
    chk(zero_freq == 1'b0, "R8", zero_freq, 0);

    // R9: leaving the frequency modes clears the flag and stops results
    cur_req = "R9";
    in_z = 1'b1;
    tick(270);
    chk(zero_freq == 1'b1, "R9 before", zero_freq, 1);
    mode = 3'd0;
    tick(2);
    chk(zero_freq == 1'b0, "R9", zero_freq, 0);
    in_z = 1'b0;
    tick(10);
    z_phase(20, 1'b1);
    chk(update_tag == last_tag, "R9 no update", update_tag, last_tag);

    // R6: single mode needs arm, one result per arm
    mode = 3'd5; cur_req = "R6";
    tick(5);
    z_phase(20, 1'b1);
    chk(update_tag == last_tag, "R6 unarmed", update_tag, last_tag);
    arm = 1'b1; tick(1); arm = 1'b0; tick(3);
    expect_result(20, 0); z_phase(20, 1'b1);
    z_phase(12, 1'b1);
    chk(update_tag == last_tag, "R6 one shot", update_tag, last_tag);
    chk(stored_count == 20, "R6 one shot", stored_count, 20);

    // R4: rate intervals of 10 ms ticks, 4 clocks per tick
    mode = 3'd0; tick(3);
    timebase = 8'd10; cur_req = "R4";
    mode = 3'd7;
    rate_interval(5);
    rate_interval(0);
    cur_req = "R8";
    rate_interval(3);
    tick(5);
    mode = 3'd0;
    tick(10);
    chk(exp_cnt_q.size() == 0, "R5 all results", exp_cnt_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule